// File: doc/BRIEF.md
# Bit-Serial Winner-Take-All Best-Matching-Unit Search

This block picks the best matching unit of a self-organizing map holding 256 nodes on a 16 by 16 grid. A distance stage elsewhere computes an 11-bit distance for every node. This block does not receive those distances as words. Each node drives one line, `dist_bits[n]`, and sends its distance on it one bit per clock, most significant bit first. The block keeps one candidate flag per node. On each bit it drops every candidate that shows a 1 while some other candidate shows a 0. After the last bit, only the nodes at the minimum distance remain.

Several nodes can remain tied. To settle this, a pointer starts at a position taken from a free-running 16-bit maximal-length LFSR. It steps through the node indices one per clock, wrapping at the end, until it reaches a surviving candidate. A single survivor goes through the same scan. The block then raises `done` for one clock and presents the winner's index, packed as row and column. A new search begins with a `start` pulse while the block is idle.

Top module: `som_wta_bmu_search`

## Requirements
- R1: While reset is held, `done` and `busy` are 0 and `winner_idx` is 0.
- R2: A `start` sampled high while `busy` is 0 marks all 256 nodes as candidates, and `busy` is 1 on the following cycle.
- R3: In each bit cycle, if any surviving candidate shows a 0, every surviving candidate showing a 1 is dropped. If all survivors show 1, none is dropped. A dropped node never returns before the next accepted `start`.
- R4: The 11 distance bits are taken most significant first. The bit of weight 2^(10-k) is sampled on the (k+1)-th rising edge after the edge that accepted `start`, for k = 0 to 10.
- R5: When exactly one node has the smallest distance, that node is reported.
- R6: When several nodes share the smallest distance, the reported node is one of them. It is the first survivor at or after the LFSR-derived start position, stepping +1 modulo 256.
- R7: `done` is high for exactly one cycle per search, and `busy` is 0 in that cycle. `winner_idx` changes only together with `done` and holds its value until the next `done`.
- R8: A `start` sampled while `busy` is 1 has no effect. The running search completes with the result of its own distances.
- R9: `winner_idx` is the node number n = row*16 + col: the row in bits 7:4 and the column in bits 3:0. Node n drives `dist_bits[n]`.
- R10: Repeated searches with all 256 nodes tied do not always report the same node.
- R11: `done` rises between 12 and 267 rising edges after the edge that accepted `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a search when idle |
| dist_bits | input | 256 | Current distance bit of every node, MSB first |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle strobe: winner_idx is new |
| winner_idx | output | 8 | Winning node, row in 7:4, column in 3:0 |

## Verification
The assertions assume that `start` is a synchronous single-cycle pulse. They also assume that `dist_bits` carries the bit of the current bit cycle and is stable around each rising edge. The bench meets this by changing every input only on the falling edge. It drives exactly eleven bit cycles that line up with the edge that accepted `start`, and it drives zeros outside them. Stray `start` pulses during a search are applied on purpose to exercise R8. The scan bound assumes that the bit phase never leaves the candidate set empty, which follows from R3 for any input pattern.

// File: rtl/som_wta_pkg.sv
package som_wta_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BITS = 2'd1,
    ST_SCAN = 2'd2
  } wta_state_e;
endpackage

// File: rtl/som_wta_lfsr.sv
module som_wta_lfsr #(
  parameter int          W    = 16,
  parameter logic [15:0] TAPS = 16'hB400,
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_en,
  output logic [W-1:0] state_o
);
  logic [W-1:0] lfsr_q, lfsr_n;

  always_comb begin
    lfsr_n = lfsr_q;
    if (step_en) begin
      if (lfsr_q[0]) lfsr_n = (lfsr_q >> 1) ^ TAPS[W-1:0];
      else           lfsr_n = lfsr_q >> 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr_q <= SEED[W-1:0];
    else        lfsr_q <= lfsr_n;
  end

  assign state_o = lfsr_q;
endmodule

// File: rtl/som_wta_elim.sv
module som_wta_elim #(
  parameter int N = 256
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         elim_en_i,
  input  logic [N-1:0] bits_i,
  output logic [N-1:0] cand_o
);
  logic [N-1:0] cand_q, cand_n, zero_hold;
  logic         zero_seen;

  // candidates still alive that show a 0 on this bit
  assign zero_hold = cand_q & ~bits_i;
  assign zero_seen = |zero_hold;

  always_comb begin
    cand_n = cand_q;
    if (load_i)                      cand_n = '1;
    else if (elim_en_i && zero_seen) cand_n = zero_hold;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cand_q <= '0;
    else        cand_q <= cand_n;
  end

  assign cand_o = cand_q;
endmodule

// File: rtl/som_wta_scan.sv
module som_wta_scan #(
  parameter int N     = 256,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seed_load_i,
  input  logic [IDX_W-1:0] seed_i,
  input  logic             step_en_i,
  input  logic [N-1:0]     cand_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] ptr_o
);
  logic [IDX_W-1:0] ptr_q, ptr_n;

  always_comb begin
    ptr_n = ptr_q;
    if (seed_load_i)    ptr_n = seed_i;
    else if (step_en_i) ptr_n = ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_n;
  end

  assign hit_o = cand_i[ptr_q];
  assign ptr_o = ptr_q;
endmodule

// File: rtl/som_wta_bmu_search.sv
module som_wta_bmu_search
  import som_wta_pkg::*;
#(
  parameter int          ROWS      = 16,
  parameter int          COLS      = 16,
  parameter int          DIST_W    = 11,
  parameter int          LFSR_W    = 16,
  parameter logic [15:0] LFSR_TAPS = 16'hB400,
  parameter logic [15:0] LFSR_SEED = 16'hACE1,
  localparam int         NODES     = ROWS * COLS,
  localparam int         IDX_W     = $clog2(NODES),
  localparam int         CNT_W     = $clog2(DIST_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NODES-1:0] dist_bits,
  output logic             busy,
  output logic             done,
  output logic [IDX_W-1:0] winner_idx
);
  wta_state_e       state_q, state_n;
  logic [CNT_W-1:0] bit_cnt_q, bit_cnt_n;
  logic             done_q, done_n;
  logic [IDX_W-1:0] idx_q, idx_n;

  logic             load_c, elim_c, seed_c, step_c;
  logic [NODES-1:0] cand_w;
  logic [LFSR_W-1:0] lfsr_w;
  logic             hit_w;
  logic [IDX_W-1:0] ptr_w;

  som_wta_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .step_en(1'b1), .state_o(lfsr_w)
  );

  som_wta_elim #(.N(NODES)) u_elim (
    .clk(clk), .rst_n(rst_n), .load_i(load_c), .elim_en_i(elim_c),
    .bits_i(dist_bits), .cand_o(cand_w)
  );

  som_wta_scan #(.N(NODES), .IDX_W(IDX_W)) u_scan (
    .clk(clk), .rst_n(rst_n), .seed_load_i(seed_c),
    .seed_i(lfsr_w[IDX_W-1:0]), .step_en_i(step_c),
    .cand_i(cand_w), .hit_o(hit_w), .ptr_o(ptr_w)
  );

  always_comb begin
    state_n   = state_q;
    bit_cnt_n = bit_cnt_q;
    idx_n     = idx_q;
    done_n    = 1'b0;
    load_c    = 1'b0;
    elim_c    = 1'b0;
    seed_c    = 1'b0;
    step_c    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          load_c    = 1'b1;
          bit_cnt_n = '0;
          state_n   = ST_BITS;
        end
      end
      ST_BITS: begin
        elim_c    = 1'b1;
        bit_cnt_n = bit_cnt_q + 1'b1;
        if (bit_cnt_q == CNT_W'(DIST_W - 1)) begin
          seed_c  = 1'b1;
          state_n = ST_SCAN;
        end
      end
      ST_SCAN: begin
        if (hit_w) begin
          done_n  = 1'b1;
          idx_n   = ptr_w;
          state_n = ST_IDLE;
        end else begin
          step_c  = 1'b1;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      done_q    <= 1'b0;
      idx_q     <= '0;
    end else begin
      state_q   <= state_n;
      bit_cnt_q <= bit_cnt_n;
      done_q    <= done_n;
      idx_q     <= idx_n;
    end
  end

  assign busy       = (state_q != ST_IDLE);
  assign done       = done_q;
  assign winner_idx = idx_q;
endmodule

// File: rtl/som_wta_bmu_search_chk.sv
module som_wta_bmu_search_chk #(
  parameter int N      = 256,
  parameter int IDX_W  = 8,
  parameter int DIST_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [IDX_W-1:0] winner_idx,
  input logic [N-1:0]     cand
);
  int unsigned run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              run_cnt <= 0;
    else if (start && !busy) run_cnt <= 0;
    else if (busy)           run_cnt <= run_cnt + 1;
  end

  assert_start_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> ((&cand) && busy));

  assert_never_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (|cand));

  assert_no_revive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(start && !busy) |=> ((cand & ~$past(cand)) == '0));

  assert_winner_alive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cand[winner_idx]);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_idx_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(winner_idx) |-> done);

  assert_latency_window_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run_cnt >= DIST_W + 1 && run_cnt <= DIST_W + N));
endmodule

bind som_wta_bmu_search som_wta_bmu_search_chk #(
  .N(NODES), .IDX_W(IDX_W), .DIST_W(DIST_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .winner_idx(winner_idx), .cand(cand_w)
);

// File: tb/som_wta_bmu_search_bench.sv
module som_wta_bmu_search_bench;
  localparam int N  = 256;
  localparam int DW = 11;

  typedef struct {
    logic [N-1:0] mask;
    int           t0;
    logic [7:0]   exp;
    string        req;
  } item_t;

  logic         clk, rst_n, start, busy, done;
  logic [N-1:0] dist_bits;
  logic [7:0]   winner_idx;

  int           n_checks, n_errs, cyc;
  item_t        sb_q[$];
  logic [DW-1:0] dist_v [N];
  logic         prev_done;
  logic [7:0]   prev_idx, last_win;

  som_wta_bmu_search u_som_wta_bmu_search (
    .clk(clk), .rst_n(rst_n), .start(start), .dist_bits(dist_bits),
    .busy(busy), .done(done), .winner_idx(winner_idx)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pops expected items as results appear
  always @(negedge clk) begin
    item_t it;
    int    lat;
    if (rst_n && prev_done) begin
      check(!done, "R7 done one cycle", int'(done), 0);
      check(winner_idx == prev_idx, "R7 index held", int'(winner_idx), int'(prev_idx));
    end
    if (rst_n && done) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R7 unexpected done", 1, 0);
      end else begin
        it  = sb_q.pop_front();
        lat = cyc - it.t0;
        check(it.mask[winner_idx], {it.req, " winner in minimum set"}, int'(winner_idx), int'(it.exp));
        check(lat >= 13 && lat <= 268, "R11 latency window", lat, 13);
        check(!busy, "R7 busy low with done", int'(busy), 0);
        if ($countones(it.mask) == 1)
          check(winner_idx == it.exp, "R9 exact index", int'(winner_idx), int'(it.exp));
        last_win = winner_idx;
      end
    end
    prev_done = done;
    prev_idx  = winner_idx;
  end

  // driver: computes expectation, pushes it, then serialises the distances
  task automatic run_search(input string req, input bit poke_start);
    item_t         it;
    logic [DW-1:0] mn;
    bit            found;
    mn = '1;
    for (int n = 0; n < N; n++) if (dist_v[n] < mn) mn = dist_v[n];
    found = 1'b0;
    it.exp = 8'd0;
    for (int n = 0; n < N; n++) begin
      it.mask[n] = (dist_v[n] == mn);
      if (it.mask[n] && !found) begin
        it.exp = 8'(n);
        found  = 1'b1;
      end
    end
    it.req = req;
    @(negedge clk);
    it.t0 = cyc;
    sb_q.push_back(it);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy, "R2 busy after start", int'(busy), 1);
    for (int b = DW - 1; b >= 0; b--) begin
      for (int n = 0; n < N; n++) dist_bits[n] = dist_v[n][b];
      start = poke_start && (b == DW - 4 || b == 1);
      @(negedge clk);
    end
    start     = 1'b0;
    dist_bits = '0;
    wait (sb_q.size() == 0);
    @(negedge clk);
  endtask

  task automatic fill(input logic [DW-1:0] v);
    for (int n = 0; n < N; n++) dist_v[n] = v;
  endtask

  initial begin
    int distinct;
    logic [7:0] seen [8];
    cyc = 0; n_checks = 0; n_errs = 0;
    prev_done = 1'b0; prev_idx = 8'd0; last_win = 8'd0;
    rst_n = 1'b0; start = 1'b0; dist_bits = '0;
    repeat (3) @(negedge clk);
    check(!done, "R1 reset done", int'(done), 0);
    check(!busy, "R1 reset busy", int'(busy), 0);
    check(winner_idx == 8'd0, "R1 reset index", int'(winner_idx), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R5 R9: unique minimum at row 5 column 9
    fill(11'd1000); dist_v[8'h59] = 11'd999;
    run_search("R5 R9 row5 col9", 1'b0);
    fill(11'd700); dist_v[0] = 11'd3;
    run_search("R5 node 0", 1'b0);
    fill(11'd700); dist_v[255] = 11'd699;
    run_search("R5 node 255", 1'b0);

    // R4: MSB-first ordering; 1023 beats 1024
    fill(11'd1024); dist_v[40] = 11'd1023;
    run_search("R4 MSB first", 1'b0);

    // R3: all survivors show 1 on the MSB, nothing dropped there
    for (int n = 0; n < N; n++) dist_v[n] = 11'(1025 + (n % 900));
    dist_v[17] = 11'd1024;
    run_search("R3 all-ones bit keeps set", 1'b0);

    // R6: two-way tie
    for (int k = 0; k < 3; k++) begin
      for (int n = 0; n < N; n++) dist_v[n] = 11'($urandom_range(2047, 6));
      dist_v[3] = 11'd5; dist_v[200] = 11'd5;
      run_search("R6 two-way tie", 1'b0);
    end
    fill(11'd2047);
    run_search("R6 full tie at max", 1'b0);
    fill(11'd0);
    run_search("R6 full tie at zero", 1'b0);

    // R5 R6: random distances
    for (int k = 0; k < 12; k++) begin
      for (int n = 0; n < N; n++) dist_v[n] = 11'($urandom_range(2047, 0));
      run_search("R5 R6 random", 1'b0);
    end

    // R8: start pulses during a search are ignored
    fill(11'd900); dist_v[77] = 11'd100;
    run_search("R8 start while busy", 1'b1);
    for (int n = 0; n < N; n++) dist_v[n] = 11'($urandom_range(2047, 0));
    run_search("R8 start while busy random", 1'b1);

    // R10: full ties spread over different winners
    fill(11'd333);
    for (int k = 0; k < 8; k++) begin
      repeat (k * 3 + 1) @(negedge clk);
      run_search("R10 tie spread", 1'b0);
      seen[k] = last_win;
    end
    distinct = 0;
    for (int k = 0; k < 8; k++) begin
      bit dup;
      dup = 1'b0;
      for (int j = 0; j < k; j++) if (seen[j] == seen[k]) dup = 1'b1;
      if (!dup) distinct++;
    end
    check(distinct >= 2, "R10 distinct tie winners", distinct, 2);

    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    check(1'b0, "watchdog expired", cyc, 150000);
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule